// File: doc/BRIEF.md
# Bidirectional Strobed Bus Port

This block runs one 8-bit peripheral bus in both directions with a handshake. A CPU write to the port fills an output latch and raises a "buffer full" flag toward the peripheral. The peripheral answers with an acknowledge pulse. The bus is driven only while that acknowledge is low. In the other direction, the peripheral places data on the bus and pulses a strobe. The strobe fills a separate input latch and raises an "input full" flag, and a CPU read of the latch empties that flag.

A single interrupt request covers both directions. The output side can set it on the end of an acknowledge, and the input side can set it on the end of a strobe. Each side has its own enable, written through single-bit set/reset commands. How the request clears depends on which side, or both, set it. The block also assembles the status byte returned when the control port is read; its three low bits come unchanged from the neighbouring group.

All inputs are sampled on `clk`. Every registered output changes on the clock edge at which the causing input level is first sampled. The bus enable follows the acknowledge line without a register.

Top module: `bidir_strobe_port`

## Requirements
- R1: After reset, `obf_n` is 1, `ibf` and `intr` are 0, both interrupt enables are 0, and both latches hold 0.
- R2: A rising edge of `cpu_wr_n` loads `cpu_wdata` into the output latch and drives `obf_n` low. A falling edge of `ack_n` returns `obf_n` high. When both happen in the same cycle, `obf_n` ends low.
- R3: `pa_oe` is 1 exactly while `ack_n` is 0. `pa_out` always shows the output latch.
- R4: In every cycle that `stb_n` is sampled low, the input latch takes `pa_in` and `ibf` goes to 1. While `stb_n` is high the latch holds. A rising edge of `cpu_rd_n` clears `ibf`, but a strobe in the same cycle keeps it at 1. `cpu_rdata` shows the input latch.
- R5: A set/reset command (`bsr_we`=1) with `bsr_sel`=6 writes `bsr_val` into the output-side enable, and with `bsr_sel`=4 writes it into the input-side enable. Any other `bsr_sel` value changes no state.
- R6: `intr` is set by a rising edge of `ack_n` only while the output-side enable is 1, and by a rising edge of `stb_n` only while the input-side enable is 1.
- R7: When only the acknowledge source has set `intr`, a falling edge of `cpu_wr_n` clears it and a falling edge of `cpu_rd_n` does not.
- R8: When only the strobe source has set `intr`, a falling edge of `cpu_rd_n` clears it and a falling edge of `cpu_wr_n` does not.
- R9: When both sources have set `intr`, it clears on a `cpu_wr_n` falling edge only after a complete read pulse, or on a `cpu_rd_n` falling edge only after a complete write pulse. A pulse counts only if it ends after both sources have set the request.
- R10: `status` bit 7 is `obf_n`, bit 6 is the output-side enable, bit 5 is `ibf`, bit 4 is the input-side enable, bit 3 is `intr`, and bits 2:0 equal `grpb_stat`.
- R11: A `mode_set` pulse clears both enables, `ibf`, `intr` and the output latch, and returns `obf_n` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_wr_n | input | 1 | CPU write strobe for the port, active low |
| cpu_rd_n | input | 1 | CPU read strobe for the port, active low |
| cpu_wdata | input | 8 | Data written by the CPU |
| cpu_rdata | output | 8 | Input latch contents for the CPU |
| mode_set | input | 1 | Mode-set write pulse |
| bsr_we | input | 1 | Single-bit set/reset command valid |
| bsr_sel | input | 3 | Bit number addressed by the command |
| bsr_val | input | 1 | Value written by the command |
| pa_in | input | 8 | Peripheral bus value seen at the pins |
| pa_out | output | 8 | Output latch value for the bus |
| pa_oe | output | 1 | Bus driver enable |
| ack_n | input | 1 | Peripheral acknowledge, active low |
| stb_n | input | 1 | Peripheral strobe, active low |
| grpb_stat | input | 3 | Low status bits from the neighbouring group |
| obf_n | output | 1 | Output buffer full, active low |
| ibf | output | 1 | Input buffer full |
| intr | output | 1 | Interrupt request |
| status | output | 8 | Status byte for a control-port read |

## Verification
Two pairs of functions can fall in the same cycle. In the first pair, the CPU write that fills the output latch coincides with the acknowledge that empties it. In the second, the strobe that fills the input latch coincides with the end of the CPU read that empties it. The bench drives `cpu_wr_n` high in the same cycle that `ack_n` falls, and drives `stb_n` low in the same cycle that `cpu_rd_n` rises. It then checks that the filling side wins: `obf_n` stays low and `ibf` stays high. It also checks that the latches hold the newly written or strobed data.

// File: rtl/sp_pkg.sv
package sp_pkg;
    parameter int unsigned SP_DW = 8;
    parameter int unsigned SP_NLINES = 4;

    // handshake line positions inside the edge-detector vector
    localparam int unsigned LN_WR  = 0;
    localparam int unsigned LN_RD  = 1;
    localparam int unsigned LN_ACK = 2;
    localparam int unsigned LN_STB = 3;

    // set/reset bit numbers that reach the enables
    localparam logic [2:0] SEL_EN_OUT = 3'd6;
    localparam logic [2:0] SEL_EN_IN  = 3'd4;

    typedef struct packed {
        logic [SP_DW-1:0] out_lat;
        logic [SP_DW-1:0] in_lat;
        logic             obf_n;
        logic             ibf;
        logic             en_out;
        logic             en_in;
    } port_state_t;

    typedef struct packed {
        logic from_ack;
        logic from_stb;
        logic rd_done;
        logic wr_done;
    } irq_state_t;
endpackage

// File: rtl/sp_edge_det.sv
module sp_edge_det #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lines_n,
    output logic [N-1:0] fall,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lines_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= prev_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_line
        assign fall[i] = prev_q[i] & ~lines_n[i];
        assign rise[i] = ~prev_q[i] & lines_n[i];
    end
endmodule

// File: rtl/sp_irq_ctrl.sv
module sp_irq_ctrl
    import sp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr_mode,
    input  logic set_ack,
    input  logic set_stb,
    input  logic wr_fall,
    input  logic wr_rise,
    input  logic rd_fall,
    input  logic rd_rise,
    output logic intr
);
    irq_state_t s_d, s_q;
    logic both, only_ack, only_stb, clr;

    always_comb begin
        s_d      = s_q;
        both     = s_q.from_ack & s_q.from_stb;
        only_ack = s_q.from_ack & ~s_q.from_stb;
        only_stb = s_q.from_stb & ~s_q.from_ack;
        clr      = clr_mode
                 | (only_ack & wr_fall)
                 | (only_stb & rd_fall)
                 | (both & ((wr_fall & s_q.rd_done) | (rd_fall & s_q.wr_done)));
        if (clr) begin
            s_d = '0;
        end else if (both) begin
            if (rd_rise) s_d.rd_done = 1'b1;
            if (wr_rise) s_d.wr_done = 1'b1;
        end
        if (!clr_mode && (set_ack || set_stb)) begin
            if (set_ack) s_d.from_ack = 1'b1;
            if (set_stb) s_d.from_stb = 1'b1;
            s_d.rd_done = 1'b0;
            s_d.wr_done = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign intr = s_q.from_ack | s_q.from_stb;

    // R6
    intr_set_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(intr) |-> $past(set_ack | set_stb));
    // R7
    intr_clr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(intr) |-> $past(wr_fall | rd_fall | clr_mode));
endmodule

// File: rtl/bidir_strobe_port.sv
module bidir_strobe_port
    import sp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_wr_n,
    input  logic             cpu_rd_n,
    input  logic [SP_DW-1:0] cpu_wdata,
    output logic [SP_DW-1:0] cpu_rdata,
    input  logic             mode_set,
    input  logic             bsr_we,
    input  logic [2:0]       bsr_sel,
    input  logic             bsr_val,
    input  logic [SP_DW-1:0] pa_in,
    output logic [SP_DW-1:0] pa_out,
    output logic             pa_oe,
    input  logic             ack_n,
    input  logic             stb_n,
    input  logic [2:0]       grpb_stat,
    output logic             obf_n,
    output logic             ibf,
    output logic             intr,
    output logic [7:0]       status
);
    port_state_t p_d, p_q;
    logic [SP_NLINES-1:0] lines_n, fall, rise;
    logic wr_fall, wr_rise, rd_fall, rd_rise, ack_fall, ack_rise, stb_rise;

    assign lines_n = {stb_n, ack_n, cpu_rd_n, cpu_wr_n};

    sp_edge_det #(.N(SP_NLINES)) u_edges (
        .clk    (clk),
        .rst_n  (rst_n),
        .lines_n(lines_n),
        .fall   (fall),
        .rise   (rise)
    );

    assign wr_fall  = fall[LN_WR];
    assign wr_rise  = rise[LN_WR];
    assign rd_fall  = fall[LN_RD];
    assign rd_rise  = rise[LN_RD];
    assign ack_fall = fall[LN_ACK];
    assign ack_rise = rise[LN_ACK];
    assign stb_rise = rise[LN_STB];

    always_comb begin
        p_d = p_q;
        if (mode_set) begin
            p_d.out_lat = '0;
            p_d.obf_n   = 1'b1;
            p_d.ibf     = 1'b0;
            p_d.en_out  = 1'b0;
            p_d.en_in   = 1'b0;
        end else begin
            if (ack_fall) p_d.obf_n = 1'b1;
            if (wr_rise) begin
                p_d.out_lat = cpu_wdata;
                p_d.obf_n   = 1'b0;
            end
            if (rd_rise) p_d.ibf = 1'b0;
            if (!stb_n) begin
                p_d.in_lat = pa_in;
                p_d.ibf    = 1'b1;
            end
            if (bsr_we) begin
                if (bsr_sel == SEL_EN_OUT) p_d.en_out = bsr_val;
                if (bsr_sel == SEL_EN_IN)  p_d.en_in  = bsr_val;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q       <= '0;
            p_q.obf_n <= 1'b1;
        end else begin
            p_q <= p_d;
        end
    end

    sp_irq_ctrl u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_mode(mode_set),
        .set_ack (ack_rise & p_q.en_out),
        .set_stb (stb_rise & p_q.en_in),
        .wr_fall (wr_fall),
        .wr_rise (wr_rise),
        .rd_fall (rd_fall),
        .rd_rise (rd_rise),
        .intr    (intr)
    );

    assign pa_out    = p_q.out_lat;
    assign pa_oe     = ~ack_n;
    assign cpu_rdata = p_q.in_lat;
    assign obf_n     = p_q.obf_n;
    assign ibf       = p_q.ibf;
    assign status    = {p_q.obf_n, p_q.en_out, p_q.ibf, p_q.en_in, intr, grpb_stat};

    // R2
    obf_set_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(p_q.obf_n) |-> $past(wr_rise));
    // R2
    obf_rel_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(p_q.obf_n) |-> $past(ack_fall | mode_set));
    // R4
    ibf_set_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(p_q.ibf) |-> $past(!stb_n));
    // R11
    mode_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_set |=> (!p_q.en_out && !p_q.en_in && p_q.obf_n && !p_q.ibf && !intr));
endmodule

// File: tb/sim_bidir_strobe_port.sv
module sim_bidir_strobe_port;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 18;
    localparam logic [2:0] GB = 3'b101;

    // {wr_n,rd_n,ack_n,stb_n, wdata, pa_in, exp{obf_n,ibf,intr,oe}, exp pa_out, exp rdata}
    localparam logic [39:0] VEC [NVEC] = '{
        40'h7_A5_00_8_00_00, 40'hF_A5_00_0_A5_00, 40'hD_A5_00_9_A5_00,
        40'hF_A5_00_8_A5_00, 40'hE_A5_3C_C_A5_3C, 40'hF_A5_FF_C_A5_3C,
        40'hB_A5_FF_C_A5_3C, 40'hF_A5_FF_8_A5_3C, 40'h7_5A_FF_8_A5_3C,
        40'hD_5A_FF_1_5A_3C, 40'hF_5A_FF_0_5A_3C, 40'hD_5A_FF_9_5A_3C,
        40'hF_5A_FF_8_5A_3C, 40'hB_5A_FF_8_5A_3C, 40'hE_5A_C3_C_5A_C3,
        40'hF_5A_C3_C_5A_C3, 40'hB_5A_C3_C_5A_C3, 40'hF_5A_C3_8_5A_C3
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic cpu_wr_n = 1'b1, cpu_rd_n = 1'b1, ack_n = 1'b1, stb_n = 1'b1;
    logic mode_set = 1'b0, bsr_we = 1'b0, bsr_val = 1'b0;
    logic [2:0] bsr_sel = '0;
    logic [7:0] cpu_wdata = '0, pa_in = '0;
    logic [2:0] grpb_stat = GB;
    logic [7:0] cpu_rdata, pa_out, status;
    logic pa_oe, obf_n, ibf, intr;
    int n_chk = 0, n_bad = 0;

    bidir_strobe_port u0 (
        .clk(clk), .rst_n(rst_n), .cpu_wr_n(cpu_wr_n), .cpu_rd_n(cpu_rd_n),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .mode_set(mode_set),
        .bsr_we(bsr_we), .bsr_sel(bsr_sel), .bsr_val(bsr_val), .pa_in(pa_in),
        .pa_out(pa_out), .pa_oe(pa_oe), .ack_n(ack_n), .stb_n(stb_n),
        .grpb_stat(grpb_stat), .obf_n(obf_n), .ibf(ibf), .intr(intr), .status(status)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bsr(input logic [2:0] sel, input logic val);
        bsr_we = 1'b1; bsr_sel = sel; bsr_val = val;
        step();
        bsr_we = 1'b0;
    endtask

    // R10 layout: obf_n, en_out, ibf, en_in, intr, group B bits
    function automatic logic [7:0] st(input logic o, input logic e1, input logic i,
                                      input logic e2, input logic q);
        return {o, e1, i, e2, q, GB};
    endfunction

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        // R1 reset state, R10 status layout
        chk("R1 status in reset", status, st(1, 0, 0, 0, 0));
        chk("R1 latches in reset", {pa_out | cpu_rdata}, 8'h00);
        rst_n = 1'b1;
        step();
        chk("R1 flags after reset", {4'h0, obf_n, ibf, intr, pa_oe}, 8'h08);
        chk("R10 status after reset", status, st(1, 0, 0, 0, 0));

        // R2 R3 R4 handshake table, including same-cycle fill/empty
        for (int k = 0; k < NVEC; k++) begin
            {cpu_wr_n, cpu_rd_n, ack_n, stb_n} = VEC[k][39:36];
            cpu_wdata = VEC[k][35:28];
            pa_in     = VEC[k][27:20];
            step();
            chk($sformatf("R2/R3/R4 vec%0d flags", k), {4'h0, obf_n, ibf, intr, pa_oe},
                {4'h0, VEC[k][19:16]});
            chk($sformatf("R3 vec%0d pa_out", k), pa_out, VEC[k][15:8]);
            chk($sformatf("R4 vec%0d rdata", k), cpu_rdata, VEC[k][7:0]);
        end

        // R5 enable writes
        bsr(3'd6, 1'b1);
        chk("R5 output enable set", status, st(1, 1, 0, 0, 0));
        // R7 ack-only source
        cpu_wr_n = 0; step(); cpu_wr_n = 1; step();
        ack_n = 0; step(); ack_n = 1; step();
        chk("R6 ack rise sets intr", {7'h0, intr}, 8'h01);
        cpu_rd_n = 0; step(); cpu_rd_n = 1; step();
        chk("R7 read does not clear ack intr", {7'h0, intr}, 8'h01);
        cpu_wr_n = 0; step();
        chk("R7 write fall clears ack intr", {7'h0, intr}, 8'h00);
        cpu_wr_n = 1; step();
        bsr(3'd6, 1'b0);
        ack_n = 0; step(); ack_n = 1; step();
        chk("R6 ack rise gated by disabled enable", {7'h0, intr}, 8'h00);

        bsr(3'd4, 1'b1);
        chk("R5 input enable set", status, st(1, 0, 0, 1, 0));
        bsr(3'd5, 1'b1);
        bsr(3'd3, 1'b1);
        chk("R5 other selects ignored", status, st(1, 0, 0, 1, 0));

        // R8 strobe-only source
        pa_in = 8'h77;
        stb_n = 0; step(); stb_n = 1; step();
        chk("R6 stb rise sets intr", status, st(1, 0, 1, 1, 1));
        cpu_wr_n = 0; step();
        chk("R8 write does not clear stb intr", {7'h0, intr}, 8'h01);
        cpu_wr_n = 1; step();
        cpu_rd_n = 0; step();
        chk("R8 read fall clears stb intr", {7'h0, intr}, 8'h00);
        cpu_rd_n = 1; step();

        // R9 both sources
        bsr(3'd6, 1'b1);
        ack_n = 0; step(); ack_n = 1; step();
        stb_n = 0; step(); stb_n = 1; step();
        chk("R9 both set", {7'h0, intr}, 8'h01);
        cpu_wr_n = 0; step();
        chk("R9 write fall without prior read pulse keeps intr", {7'h0, intr}, 8'h01);
        cpu_wr_n = 1; step();
        cpu_rd_n = 0; step();
        chk("R9 read fall after write pulse clears intr", {7'h0, intr}, 8'h00);
        cpu_rd_n = 1; step();

        // R11 mode set
        stb_n = 0; step(); stb_n = 1; step();
        chk("R11 state before mode set", status, st(0, 1, 1, 1, 1));
        mode_set = 1; step(); mode_set = 0;
        chk("R11 status after mode set", status, st(1, 0, 0, 0, 0));
        chk("R11 output latch after mode set", pa_out, 8'h00);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule